// File: doc/BRIEF.md
# Register Lineage Filter for Metadata-Propagation Events

This block sits on the stream of per-instruction monitoring events that flows from the event-capture logic to the software handlers, which keep shadow metadata for memory and registers. For each architectural register it keeps a small record. The record says whether the register's metadata is currently a copy of one memory location's metadata, and if so which address. With this record the block can defer register metadata updates instead of sending each one. A load into a register is absorbed. A later store from that register becomes a single memory-to-memory copy. The deferred load is only sent out when it can no longer be postponed.

Only single-source (unary) lineage is recorded. An operation that combines a register with memory is never tracked. Instead it forces the register's pending lineage out as a deferred load, and after that the register owns its own metadata. Any write to a memory location that some register still depends on first flushes those registers, so the shadow state stays correct. When tracking is switched off, the block forwards every event unchanged. A flush-all command empties the record.

Both sides use valid/ready handshakes. The output is registered. When one input event expands into several output events, they leave one per cycle and the input is held.

Top module: `reg_lineage_filter`

## Requirements
- R1: After a synchronous active-high reset, `out_valid` is 0 and every register record is empty, so no deferred event can come from stale state.
- R2: While `track_en` is 0, each accepted event appears once on the output with kind, register and both addresses unchanged, and the register records are not modified.
- R3: With tracking on, a load event (kind 0: memory `in_src` to register `in_reg`) produces no output. It records that register `in_reg` derives from `in_src`, replacing any earlier record for that register.
- R4: With tracking on, a store event (kind 1: register `in_reg` to memory `in_dst`) whose register holds a record for address A is emitted as one copy event: kind 2, register field 0, `out_src` = A, `out_dst` = `in_dst`. The record is kept.
- R5: With tracking on, a store from a register without a record, a copy event (kind 2) and an immediate-to-memory event (kind 3) are forwarded unchanged, after any flushes from R6.
- R6: A write to memory address X (kinds 1, 2, 3) first flushes every register whose record names X, in ascending register order. Each flush emits a deferred load (kind 0, register = that index, `out_src` = X, `out_dst` = 0) and clears the record. The write event follows these flushes.
- R7: An operation event (kind 4: register `in_reg` combined with memory `in_src`) on a register with a record first emits that register's deferred load, then the operation event unchanged. The register is left without a record.
- R8: A flush-all command (kind 5) emits a deferred load for every register with a record, in ascending register order, and clears all records. The command itself emits no event.
- R9: At most one event leaves per cycle. `out_valid` and the output fields hold while `out_ready` is 0. An input that expands into several events is not accepted until its last event is issued.
- R10: With tracking on, the unused kind codes 6 and 7 are forwarded unchanged and do not touch the records.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| track_en | input | 1 | 1 enables lineage tracking, 0 forwards everything |
| in_valid | input | 1 | Input event valid |
| in_ready | output | 1 | Input event accepted this cycle |
| in_kind | input | 3 | Event kind code |
| in_reg | input | RW (3) | Register index |
| in_src | input | AW (32) | Source address |
| in_dst | input | AW (32) | Destination address |
| out_valid | output | 1 | Output event valid |
| out_ready | input | 1 | Downstream accepts output |
| out_kind | output | 3 | Output event kind code |
| out_reg | output | RW (3) | Output register index |
| out_src | output | AW (32) | Output source address |
| out_dst | output | AW (32) | Output destination address |

## Verification
Two functions can land on one event: a store from a register that has a record for address A, sent to an address X that other registers derive from. That single event then needs conflict flushes and the store-to-copy rewrite, while output back-pressure can stall the sequence part-way. The bench provokes this with a long pseudo-random stream over four addresses and eight registers, with `out_ready` toggled at random. It judges the output by comparing the ordered event sequence against a reference model of the records, so flush order, the copy's source address and the absence of duplicate or lost events are all checked.

// File: rtl/rlf_pkg.sv
`timescale 1ns/1ps
package rlf_pkg;
  typedef enum logic [2:0] {
    EK_LOAD  = 3'd0,
    EK_STORE = 3'd1,
    EK_COPY  = 3'd2,
    EK_IMM   = 3'd3,
    EK_OPMEM = 3'd4,
    EK_FLUSH = 3'd5
  } ev_kind_e;
endpackage

// File: rtl/rlf_table.sv
`timescale 1ns/1ps
// Per-register lineage records: valid bit plus source address.
module rlf_table #(
  parameter int NREG = 8,
  parameter int AW   = 32,
  parameter int RW   = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            set_en,
  input  logic [RW-1:0]   set_idx,
  input  logic [AW-1:0]   set_addr,
  input  logic            clr_en,
  input  logic [RW-1:0]   clr_idx,
  input  logic [AW-1:0]   cmp_addr,
  input  logic [RW-1:0]   rd_idx,
  output logic            rd_valid,
  output logic [AW-1:0]   rd_addr,
  input  logic [RW-1:0]   fl_idx,
  output logic [AW-1:0]   fl_addr,
  output logic [NREG-1:0] valid_vec,
  output logic [NREG-1:0] match_vec
);
  logic [NREG-1:0] vld_q;
  logic [AW-1:0]   addr_q [NREG];

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= '0;
    end else begin
      for (int i = 0; i < NREG; i++) begin
        if (clr_en && clr_idx == RW'(i))
          vld_q[i] <= 1'b0;
        else if (set_en && set_idx == RW'(i))
          vld_q[i] <= 1'b1;
      end
    end
  end

  // address storage carries no reset; validity gates every use
  always_ff @(posedge clk) begin
    if (set_en)
      addr_q[set_idx] <= set_addr;
  end

  for (genvar g = 0; g < NREG; g++) begin : g_cmp
    assign match_vec[g] = vld_q[g] && (addr_q[g] == cmp_addr);
  end

  assign valid_vec = vld_q;
  assign rd_valid  = vld_q[rd_idx];
  assign rd_addr   = addr_q[rd_idx];
  assign fl_addr   = addr_q[fl_idx];

  // R6: a cleared record is gone in the following cycle
  p_clear_r6: assert property (@(posedge clk) disable iff (rst)
    clr_en |=> !vld_q[$past(clr_idx)]);
endmodule

// File: rtl/rlf_lowest.sv
`timescale 1ns/1ps
// Lowest-index-first selector used for ascending flush order.
module rlf_lowest #(
  parameter int N = 8,
  parameter int W = 3
) (
  input  logic [N-1:0] req,
  output logic [W-1:0] idx,
  output logic         any
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = W'(i);
    end
    // R8: the chosen index is set and no lower one is pending
    if (|req) begin
      p_lowest_r8: assert (req[idx] && ((req & ((N'(1) << idx) - N'(1))) == '0));
    end
  end
  assign any = |req;
endmodule

// File: rtl/rlf_out_reg.sv
`timescale 1ns/1ps
// Registered output stage with valid/ready.
module rlf_out_reg #(
  parameter int AW = 32,
  parameter int RW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [2:0]    d_kind,
  input  logic [RW-1:0] d_reg,
  input  logic [AW-1:0] d_src,
  input  logic [AW-1:0] d_dst,
  input  logic          out_ready,
  output logic          free,
  output logic          q_valid,
  output logic [2:0]    q_kind,
  output logic [RW-1:0] q_reg,
  output logic [AW-1:0] q_src,
  output logic [AW-1:0] q_dst
);
  assign free = !q_valid || out_ready;

  always_ff @(posedge clk) begin
    if (rst)
      q_valid <= 1'b0;
    else if (load)
      q_valid <= 1'b1;
    else if (out_ready)
      q_valid <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (load) begin
      q_kind <= d_kind;
      q_reg  <= d_reg;
      q_src  <= d_src;
      q_dst  <= d_dst;
    end
  end

  // R9: a stalled output holds its event
  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (q_valid && !out_ready) |=> (q_valid && $stable(q_kind) && $stable(q_reg)
                                 && $stable(q_src) && $stable(q_dst)));
endmodule

// File: rtl/reg_lineage_filter.sv
`timescale 1ns/1ps
module reg_lineage_filter #(
  parameter int NREG = 8,
  parameter int AW   = 32,
  localparam int RW  = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          track_en,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [2:0]    in_kind,
  input  logic [RW-1:0] in_reg,
  input  logic [AW-1:0] in_src,
  input  logic [AW-1:0] in_dst,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [2:0]    out_kind,
  output logic [RW-1:0] out_reg,
  output logic [AW-1:0] out_src,
  output logic [AW-1:0] out_dst
);
  import rlf_pkg::*;

  logic [NREG-1:0] valid_vec, match_vec, flush_req, reg_onehot;
  logic [RW-1:0]   fl_idx;
  logic            fl_any;
  logic [AW-1:0]   fl_addr, rd_addr;
  logic            rd_valid;
  logic            set_en, clr_en;
  logic            slot_free, emit;
  logic [2:0]      e_kind;
  logic [RW-1:0]   e_reg;
  logic [AW-1:0]   e_src, e_dst;
  ev_kind_e        kind;
  logic            is_write;

  assign kind       = ev_kind_e'(in_kind);
  assign is_write   = (kind == EK_STORE) || (kind == EK_COPY) || (kind == EK_IMM);
  assign reg_onehot = NREG'(1) << in_reg;

  // which records must be flushed before this event may complete
  always_comb begin
    flush_req = '0;
    if (track_en && in_valid) begin
      if (is_write)                flush_req = match_vec;
      else if (kind == EK_OPMEM)   flush_req = valid_vec & reg_onehot;
      else if (kind == EK_FLUSH)   flush_req = valid_vec;
    end
  end

  rlf_table #(.NREG(NREG), .AW(AW), .RW(RW)) u_table (
    .clk      (clk),
    .rst      (rst),
    .set_en   (set_en),
    .set_idx  (in_reg),
    .set_addr (in_src),
    .clr_en   (clr_en),
    .clr_idx  (fl_idx),
    .cmp_addr (in_dst),
    .rd_idx   (in_reg),
    .rd_valid (rd_valid),
    .rd_addr  (rd_addr),
    .fl_idx   (fl_idx),
    .fl_addr  (fl_addr),
    .valid_vec(valid_vec),
    .match_vec(match_vec)
  );

  rlf_lowest #(.N(NREG), .W(RW)) u_lowest (
    .req(flush_req),
    .idx(fl_idx),
    .any(fl_any)
  );

  always_comb begin
    in_ready = 1'b0;
    emit     = 1'b0;
    set_en   = 1'b0;
    clr_en   = 1'b0;
    e_kind   = in_kind;
    e_reg    = in_reg;
    e_src    = in_src;
    e_dst    = in_dst;
    if (!track_en) begin
      in_ready = slot_free;
      emit     = in_valid && slot_free;
    end else if (in_valid) begin
      if (fl_any) begin
        // one deferred load per cycle; input held
        emit   = slot_free;
        clr_en = slot_free;
        e_kind = EK_LOAD;
        e_reg  = fl_idx;
        e_src  = fl_addr;
        e_dst  = '0;
      end else begin
        unique case (kind)
          EK_LOAD: begin
            set_en   = 1'b1;
            in_ready = 1'b1;
          end
          EK_FLUSH: begin
            in_ready = 1'b1;
          end
          EK_STORE: begin
            in_ready = slot_free;
            emit     = slot_free;
            if (rd_valid) begin
              e_kind = EK_COPY;
              e_reg  = '0;
              e_src  = rd_addr;
            end
          end
          default: begin
            in_ready = slot_free;
            emit     = slot_free;
          end
        endcase
      end
    end
  end

  rlf_out_reg #(.AW(AW), .RW(RW)) u_out (
    .clk      (clk),
    .rst      (rst),
    .load     (emit),
    .d_kind   (e_kind),
    .d_reg    (e_reg),
    .d_src    (e_src),
    .d_dst    (e_dst),
    .out_ready(out_ready),
    .free     (slot_free),
    .q_valid  (out_valid),
    .q_kind   (out_kind),
    .q_reg    (out_reg),
    .q_src    (out_src),
    .q_dst    (out_dst)
  );

  // R2: bypass forwards the accepted event unchanged
  p_bypass_r2: assert property (@(posedge clk) disable iff (rst)
    (!track_en && in_valid && in_ready) |=>
      (out_valid && out_kind == $past(in_kind) && out_reg == $past(in_reg)
       && out_src == $past(in_src) && out_dst == $past(in_dst)));

  // R3: an absorbed load leaves a record for its register
  p_load_record_r3: assert property (@(posedge clk) disable iff (rst)
    (track_en && in_valid && in_ready && in_kind == 3'd0) |=> valid_vec[$past(in_reg)]);

  // R4: store from a register with lineage turns into a copy
  p_store_copy_r4: assert property (@(posedge clk) disable iff (rst)
    (track_en && in_valid && in_ready && in_kind == 3'd1 && rd_valid) |=>
      (out_valid && out_kind == 3'd2 && out_src == $past(rd_addr) && out_dst == $past(in_dst)));

  // R7: after an operation event the register owns its metadata
  p_opmem_own_r7: assert property (@(posedge clk) disable iff (rst)
    (track_en && in_valid && in_ready && in_kind == 3'd4) |=> !valid_vec[$past(in_reg)]);

  // R8: flush-all leaves the record table empty
  p_flush_all_r8: assert property (@(posedge clk) disable iff (rst)
    (track_en && in_valid && in_ready && in_kind == 3'd5) |=> (valid_vec == '0));
endmodule

// File: tb/tb_reg_lineage_filter.sv
`timescale 1ns/1ps
module tb_reg_lineage_filter;
  localparam int NREG = 8;
  localparam int AW   = 32;
  localparam int RW   = 3;
  localparam int EW   = 3 + RW + 2 * AW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic track_en = 1'b0;
  logic in_valid = 1'b0;
  logic [2:0] in_kind = '0;
  logic [RW-1:0] in_reg = '0;
  logic [AW-1:0] in_src = '0, in_dst = '0;
  logic in_ready;
  logic out_valid;
  logic out_ready = 1'b0;
  logic [2:0] out_kind;
  logic [RW-1:0] out_reg;
  logic [AW-1:0] out_src, out_dst;

  int n_chk = 0;
  int n_fail = 0;
  logic mv [NREG];
  logic [AW-1:0] ma [NREG];
  logic [EW-1:0] expq [$];
  string tagq [$];
  logic [15:0] rlfsr = 16'hACE1;
  logic [15:0] slfsr = 16'h1D37;
  bit rdy_rand = 1'b0;

  always #2 clk = ~clk;

  reg_lineage_filter #(.NREG(NREG), .AW(AW)) dut (
    .clk(clk), .rst(rst), .track_en(track_en),
    .in_valid(in_valid), .in_ready(in_ready), .in_kind(in_kind), .in_reg(in_reg),
    .in_src(in_src), .in_dst(in_dst),
    .out_valid(out_valid), .out_ready(out_ready), .out_kind(out_kind), .out_reg(out_reg),
    .out_src(out_src), .out_dst(out_dst));

  function automatic logic [15:0] step(input logic [15:0] v);
    return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
  endfunction

  function automatic logic [EW-1:0] pk(input logic [2:0] k, input int r,
                                       input logic [AW-1:0] s, input logic [AW-1:0] d);
    return {k, RW'(r), s, d};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [EW-1:0] act, input logic [EW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic push(input string tag, input logic [2:0] k, input int r,
                      input logic [AW-1:0] s, input logic [AW-1:0] d);
    expq.push_back(pk(k, r, s, d));
    tagq.push_back(tag);
  endtask

  task automatic flush_match(input logic [AW-1:0] d);
    for (int i = 0; i < NREG; i++) begin
      if (mv[i] && ma[i] == d) begin
        push("R6 conflict flush", 3'd0, i, ma[i], '0);
        mv[i] = 1'b0;
      end
    end
  endtask

  task automatic model(input bit en, input logic [2:0] k, input int r,
                       input logic [AW-1:0] s, input logic [AW-1:0] d);
    if (!en) begin
      push("R2 bypass forward", k, r, s, d);
    end else begin
      case (k)
        3'd0: begin mv[r] = 1'b1; ma[r] = s; end          // R3 absorbed
        3'd1: begin
          flush_match(d);
          if (mv[r]) push("R4 store as copy", 3'd2, 0, ma[r], d);
          else       push("R5 plain store", k, r, s, d);
        end
        3'd2, 3'd3: begin
          flush_match(d);
          push("R5 forwarded write", k, r, s, d);
        end
        3'd4: begin
          if (mv[r]) begin
            push("R7 deferred load", 3'd0, r, ma[r], '0);
            mv[r] = 1'b0;
          end
          push("R7 operation event", k, r, s, d);
        end
        3'd5: begin
          for (int i = 0; i < NREG; i++) begin
            if (mv[i]) push("R8 flush-all load", 3'd0, i, ma[i], '0);
            mv[i] = 1'b0;
          end
        end
        default: push("R10 unknown kind forward", k, r, s, d);
      endcase
    end
  endtask

  task automatic send(input bit en, input logic [2:0] k, input int r,
                      input logic [AW-1:0] s, input logic [AW-1:0] d);
    bit ok;
    @(negedge clk);
    track_en = en;
    in_kind  = k;
    in_reg   = RW'(r);
    in_src   = s;
    in_dst   = d;
    in_valid = 1'b1;
    model(en, k, r, s, d);
    ok = 1'b0;
    while (!ok) begin
      #1;
      ok = in_ready;
      @(posedge clk);
      if (!ok) @(negedge clk);
    end
  endtask

  task automatic idle_drain(input string tag);
    @(negedge clk);
    in_valid = 1'b0;
    for (int c = 0; c < 200 && expq.size() != 0; c++) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(expq.size() == 0 && !out_valid, tag, EW'(expq.size()), '0);
  endtask

  task automatic wrap_up();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // output monitor and ready driver
  always @(negedge clk) begin
    logic [EW-1:0] act, e;
    string t;
    if (!rst) begin
      rlfsr = step(rlfsr);
      out_ready = rdy_rand ? (rlfsr[0] | rlfsr[3]) : 1'b1;
      if (out_valid && out_ready) begin
        act = {out_kind, out_reg, out_src, out_dst};
        if (expq.size() == 0) begin
          chk(1'b0, "R3/R9 output with none expected", act, '0);
        end else begin
          e = expq.pop_front();
          t = tagq.pop_front();
          chk(act == e, t, act, e);
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog R9 actual=hung expected=complete");
    wrap_up();
  end

  initial begin
    logic [2:0] k;
    for (int i = 0; i < NREG; i++) begin mv[i] = 1'b0; ma[i] = '0; end
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    // R1 reset state
    chk(!out_valid, "R1 out_valid after reset", EW'(out_valid), '0);
    chk(in_ready, "R1 in_ready idle after reset", EW'(in_ready), EW'(1));
    // R1: empty table, store to address 0 stays a plain store
    send(1'b1, 3'd1, 0, 32'h0, 32'h0);
    idle_drain("R1 no stale records");

    // R3: loads absorbed for every register
    for (int r = 0; r < NREG; r++) send(1'b1, 3'd0, r, 32'h100 + 32'(r * 4), '0);
    idle_drain("R3 loads silent");
    // R4: stores become copies
    for (int r = 0; r < NREG; r++) send(1'b1, 3'd1, r, '0, 32'h2000 + 32'(r));
    idle_drain("R4 copies drained");
    // R6: two registers on one address, immediate write flushes both ascending
    send(1'b1, 3'd0, 5, 32'h300, '0);
    send(1'b1, 3'd0, 2, 32'h300, '0);
    send(1'b1, 3'd3, 0, '0, 32'h300);
    // R6 with R4: r3 stores to address r6 derives from
    send(1'b1, 3'd0, 6, 32'h400, '0);
    send(1'b1, 3'd1, 3, '0, 32'h400);
    // R7: operation on register with lineage, then again without
    send(1'b1, 3'd4, 0, 32'h700, '0);
    send(1'b1, 3'd4, 0, 32'h704, '0);
    idle_drain("R6 R7 drained");
    // R2: bypass leaves records untouched
    send(1'b0, 3'd0, 1, 32'h999, '0);
    send(1'b0, 3'd1, 1, '0, 32'h104);
    send(1'b0, 3'd5, 0, '0, '0);
    send(1'b1, 3'd1, 1, '0, 32'h50);
    // R10: unused codes
    send(1'b1, 3'd6, 4, 32'h11, 32'h22);
    send(1'b1, 3'd7, 7, 32'h33, 32'h44);
    // R8: flush all remaining records
    send(1'b1, 3'd5, 0, '0, '0);
    send(1'b1, 3'd5, 0, '0, '0);
    idle_drain("R2 R8 R10 drained");

    // near-exhaustive sweep with back-pressure (R9, coincident R4/R6)
    rdy_rand = 1'b1;
    for (int n = 0; n < 4000; n++) begin
      slfsr = step(step(slfsr));
      case (slfsr[3:0])
        4'd0, 4'd1, 4'd2, 4'd3, 4'd15: k = 3'd0;
        4'd4, 4'd5, 4'd6, 4'd7:        k = 3'd1;
        4'd8:                          k = 3'd2;
        4'd9:                          k = 3'd3;
        4'd10, 4'd11, 4'd12:           k = 3'd4;
        4'd13:                         k = 3'd5;
        default:                       k = 3'd6;
      endcase
      send(slfsr[8:6] != 3'd0, k, int'(slfsr[11:9]),
           32'h40 * 32'(slfsr[13:12]), 32'h40 * 32'(slfsr[15:14]));
    end
    idle_drain("R9 sweep drained");
    send(1'b1, 3'd5, 0, '0, '0);
    idle_drain("R8 final flush");
    wrap_up();
  end
endmodule